// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

A parameterised register of `WIDTH` bits whose next contents are chosen each clock by a 2-bit mode code: keep the value, move it one place toward the least significant end, move it one place toward the most significant end, or take a whole word from the parallel input. Bit `WIDTH-1` is the most significant bit and sits at the left of the parallel output. Each shift direction has its own serial fill input, and a serial output presents the bit that the current shift is about to push off the end.

The block serves as a deserialiser: a stream arriving least significant bit first is fed in at the top end while shifting right, so the first bit received ends up in bit 0 after `WIDTH` clocks. A word counter layered on the register counts right shifts and raises a one-cycle flag in the cycle the full word becomes visible. The block also serves as a serialiser: after a parallel load, repeated shifts put one bit per clock on the serial output, with the far end filled from the serial input (zeros when it is held low). All operation is on one clock with a synchronous active-high reset.

Top module: `shiftreg_univ`

## Requirements
- R1: While `rst` is high at a rising edge, the register, the word counter and `word_valid` are all cleared; `par_out` reads zero and `word_valid` reads 0 in the following cycle.
- R2: Mode code 2'b00 keeps `par_out` unchanged at the edge, whatever `par_in`, `sin_top` and `sin_bot` carry.
- R3: Mode code 2'b01 moves every bit one index down (bit i takes bit i+1) and bit `WIDTH-1` takes `sin_top`.
- R4: Mode code 2'b10 moves every bit one index up (bit i takes bit i-1) and bit 0 takes `sin_bot`; with `sin_bot` low the result equals twice the old value modulo 2^WIDTH.
- R5: Mode code 2'b11 copies `par_in` into all bits at one edge.
- R6: `ser_out` equals `par_out[0]` while the mode is 2'b01, `par_out[WIDTH-1]` while the mode is 2'b10, and 0 in the other two modes.
- R7: The mode is decoded into four select lines, exactly one of which is active in every cycle, shared by every bit stage.
- R8: `word_valid` is high for exactly one cycle, the cycle after the `WIDTH`th right shift counted since reset, the last load or the last flag; a word sent least significant bit first through `sin_top` then reads on `par_out` in its natural order in that same cycle, and counting restarts from zero.
- R9: A parallel load (2'b11) restarts the right-shift count from zero; hold (2'b00) and left shift (2'b10) leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operation select: 00 hold, 01 right, 10 left, 11 load |
| par_in | input | WIDTH | Word taken on a load |
| sin_top | input | 1 | Fill bit entering at the MSB on a right shift |
| sin_bot | input | 1 | Fill bit entering at the LSB on a left shift |
| par_out | output | WIDTH | Register contents, MSB at index WIDTH-1 |
| ser_out | output | 1 | Bit leaving the register on the current shift |
| word_valid | output | 1 | One-cycle flag: a full word has been shifted in |

## Verification
The assertions assume `mode` and the data inputs are known and settled at every rising edge and that reset is held for at least one edge at start-up, so that the next-state relations can compare the register against the previous cycle's inputs. They also assume `WIDTH` is at least 2, which is what makes the valid flag a true single-cycle pulse. The bench drives every input on the falling edge and holds it through the following rising edge, asserts reset before any other stimulus, and uses the default width of 8.

// File: rtl/shiftreg_univ_pkg.sv
package shiftreg_univ_pkg;

  typedef enum logic [1:0] {
    OP_KEEP  = 2'b00,
    OP_RIGHT = 2'b01,
    OP_LEFT  = 2'b10,
    OP_LOAD  = 2'b11
  } op_e;

  // Index of each one-hot select line.
  localparam int SEL_KEEP  = 0;
  localparam int SEL_RIGHT = 1;
  localparam int SEL_LEFT  = 2;
  localparam int SEL_LOAD  = 3;
  localparam int SEL_W     = 4;

  // Binary-to-unary conversion of the mode code.
  function automatic logic [SEL_W-1:0] op_to_sel(input logic [1:0] code);
    logic [SEL_W-1:0] s;
    s = '0;
    s[code] = 1'b1;
    return s;
  endfunction

  // Bit that leaves the register under the given selection.
  function automatic logic exit_bit(input logic [SEL_W-1:0] sel,
                                    input logic lsb_q,
                                    input logic msb_q);
    logic b;
    b = 1'b0;
    if (sel[SEL_RIGHT]) b = lsb_q;
    if (sel[SEL_LEFT])  b = msb_q;
    return b;
  endfunction

endpackage

// File: rtl/shiftreg_univ_decode.sv
module shiftreg_univ_decode
  import shiftreg_univ_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  output logic [SEL_W-1:0] sel
);

  always_comb sel = op_to_sel(mode);

  // Exactly one select line is active in every cycle.
  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);

  // The line that is active matches the code presented.
  p_sel_match_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_LOAD) |-> sel[SEL_LOAD]);

endmodule

// File: rtl/shiftreg_univ_cell.sv
module shiftreg_univ_cell
  import shiftreg_univ_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             from_hi,
  input  logic             from_lo,
  input  logic             ld_bit,
  output logic             q
);

  logic d;

  // Four-way selector steered by one-hot lines.
  always_comb begin
    d = 1'b0;
    if (sel[SEL_KEEP])  d = q;
    if (sel[SEL_RIGHT]) d = from_hi;
    if (sel[SEL_LEFT])  d = from_lo;
    if (sel[SEL_LOAD])  d = ld_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

endmodule

// File: rtl/shiftreg_univ_counter.sv
module shiftreg_univ_counter #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_evt,
  input  logic restart_evt,
  output logic word_done
);

  localparam int CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int LAST = WIDTH - 1;

  logic [CW-1:0] cnt;
  logic          at_last;

  always_comb at_last = (cnt == CW'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (restart_evt) begin
        cnt <= '0;
      end else if (shift_evt) begin
        if (at_last) begin
          cnt       <= '0;
          word_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // A load always returns the count to zero.
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    restart_evt |=> (cnt == '0));

  // Neither shift nor restart: count is frozen.
  p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!restart_evt && !shift_evt) |=> $stable(cnt));

  // Completion flag follows a shift at the last position.
  p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !restart_evt && at_last) |=> word_done);

  // Count never exceeds the last position.
  p_count_range_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LAST));

endmodule

// File: rtl/shiftreg_univ.sv
module shiftreg_univ
  import shiftreg_univ_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             sin_top,
  input  logic             sin_bot,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_out,
  output logic             word_valid
);

  localparam int MSB = WIDTH - 1;

  logic [SEL_W-1:0] sel;
  logic [WIDTH-1:0] q;
  logic             shift_evt;
  logic             restart_evt;
  logic             word_done;

  shiftreg_univ_decode u_dec (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .sel  (sel)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic hi_src;
    logic lo_src;
    if (i == MSB) begin : g_top
      always_comb hi_src = sin_top;
    end else begin : g_mid_hi
      always_comb hi_src = q[i+1];
    end
    if (i == 0) begin : g_bot
      always_comb lo_src = sin_bot;
    end else begin : g_mid_lo
      always_comb lo_src = q[i-1];
    end
    shiftreg_univ_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel),
      .from_hi (hi_src),
      .from_lo (lo_src),
      .ld_bit  (par_in[i]),
      .q       (q[i])
    );
  end

  always_comb shift_evt   = sel[SEL_RIGHT];
  always_comb restart_evt = sel[SEL_LOAD];

  shiftreg_univ_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .shift_evt   (shift_evt),
    .restart_evt (restart_evt),
    .word_done   (word_done)
  );

  always_comb par_out    = q;
  always_comb ser_out    = exit_bit(sel, q[0], q[MSB]);
  always_comb word_valid = word_done;

  // Reset clears the contents and the flag.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (par_out == '0 && !word_valid));

  p_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_KEEP) |=> $stable(par_out));

  p_right_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_RIGHT) |=> (par_out == {$past(sin_top), $past(par_out[MSB:1])}));

  p_left_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_LEFT) |=> (par_out == {$past(par_out[MSB-1:0]), $past(sin_bot)}));

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_LOAD) |=> (par_out == $past(par_in)));

  p_sout_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_KEEP || mode == OP_LOAD) |-> !ser_out);

  p_sout_right_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == OP_RIGHT) |-> (ser_out == par_out[0]));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  p_valid_after_right_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(word_valid) |-> ($past(mode) == OP_RIGHT));

endmodule

// File: tb/sim_shiftreg_univ.sv
module sim_shiftreg_univ;

  localparam int W = 8;

  typedef struct packed {
    logic [1:0]   m;
    logic [W-1:0] pin;
    logic         stop;
    logic         sbot;
    logic         exp_sout;
    logic [W-1:0] exp_q;
  } vec_t;

  // Walked in order from the reset state; each row depends on the previous.
  localparam vec_t TBL [10] = '{
    '{2'b11, 8'hA5, 1'b0, 1'b0, 1'b0, 8'hA5},  // R5 load
    '{2'b00, 8'hFF, 1'b1, 1'b1, 1'b0, 8'hA5},  // R2 hold ignores inputs
    '{2'b01, 8'h00, 1'b1, 1'b0, 1'b1, 8'hD2},  // R3 right, fill 1
    '{2'b01, 8'h00, 1'b0, 1'b1, 1'b0, 8'h69},  // R3 right, fill 0
    '{2'b10, 8'h00, 1'b1, 1'b0, 1'b0, 8'hD2},  // R4 left, fill 0 (doubling)
    '{2'b10, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA5},  // R4 left, fill 1
    '{2'b10, 8'h00, 1'b0, 1'b0, 1'b1, 8'h4A},  // R4 doubling wraps
    '{2'b11, 8'h3C, 1'b1, 1'b1, 1'b0, 8'h3C},  // R5 load
    '{2'b01, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h1E},  // R3 right
    '{2'b00, 8'h81, 1'b1, 1'b1, 1'b0, 8'h1E}   // R2 hold
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] par_in = '0;
  logic         sin_top = 1'b0;
  logic         sin_bot = 1'b0;
  logic [W-1:0] par_out;
  logic         ser_out;
  logic         word_valid;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  shiftreg_univ #(.WIDTH(W)) u0 (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .par_in     (par_in),
    .sin_top    (sin_top),
    .sin_bot    (sin_bot),
    .par_out    (par_out),
    .ser_out    (ser_out),
    .word_valid (word_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on falling edge, return after the next rising edge has settled.
  task automatic step(input logic [1:0] m, input logic [W-1:0] p,
                      input logic st, input logic sb);
    @(negedge clk);
    mode = m; par_in = p; sin_top = st; sin_bot = sb;
    @(posedge clk);
    #1;
  endtask

  task automatic shift_in(input logic b);
    step(2'b01, '0, b, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0] word;
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 par_out", 32'(par_out), 32'h0);
    check("R1 word_valid", 32'(word_valid), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      mode = TBL[k].m; par_in = TBL[k].pin;
      sin_top = TBL[k].stop; sin_bot = TBL[k].sbot;
      #1;
      check("R6 ser_out", 32'(ser_out), 32'(TBL[k].exp_sout));
      @(posedge clk);
      #1;
      check("R2-5 row par_out", 32'(par_out), 32'(TBL[k].exp_q));
      check("R8 no flag", 32'(word_valid), 32'h0);
    end

    // R6 left exit bit is the MSB
    step(2'b11, 8'h80, 1'b0, 1'b0);
    @(negedge clk);
    mode = 2'b10; #1;
    check("R6 left exit", 32'(ser_out), 32'h1);
    @(posedge clk); #1;
    check("R4 shifted out", 32'(par_out), 32'h00);

    // R1 reset mid-operation, also clears partial count
    step(2'b11, 8'h77, 1'b0, 1'b0);
    shift_in(1'b1); shift_in(1'b1);
    @(negedge clk); rst = 1'b1; mode = 2'b00;
    @(posedge clk); #1;
    check("R1 clear", 32'(par_out), 32'h0);
    @(negedge clk); rst = 1'b0;

    // R8 deserialise 0x9B LSB first
    word = 8'h9B;
    for (int b = 0; b < W; b++) begin
      shift_in(word[b]);
      if (b < W - 1) check("R8 early flag", 32'(word_valid), 32'h0);
    end
    check("R8 flag", 32'(word_valid), 32'h1);
    check("R8 word", 32'(par_out), 32'h9B);
    step(2'b00, '0, 1'b0, 1'b0);
    check("R8 one cycle", 32'(word_valid), 32'h0);

    // R8 count restarted: second word
    word = 8'h4E;
    for (int b = 0; b < W; b++) shift_in(word[b]);
    check("R8 second flag", 32'(word_valid), 32'h1);
    check("R8 second word", 32'(par_out), 32'h4E);

    // R9 hold and left do not disturb the count
    for (int b = 0; b < 3; b++) shift_in(1'b0);
    step(2'b00, '0, 1'b0, 1'b0);
    step(2'b10, '0, 1'b0, 1'b0);
    for (int b = 0; b < 4; b++) shift_in(1'b0);
    check("R9 seven shifts", 32'(word_valid), 32'h0);
    shift_in(1'b0);
    check("R9 eighth shift", 32'(word_valid), 32'h1);

    // R9 load restarts the count
    for (int b = 0; b < 3; b++) shift_in(1'b1);
    step(2'b11, 8'h00, 1'b0, 1'b0);
    for (int b = 0; b < W - 1; b++) shift_in(1'b1);
    check("R9 after load", 32'(word_valid), 32'h0);
    shift_in(1'b1);
    check("R9 full after load", 32'(word_valid), 32'h1);
    check("R3 ones filled", 32'(par_out), 32'hFF);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule